// File: doc/BRIEF.md
# Input Capture Glitch Filter

This block sits between an asynchronous capture pin and the edge-capture logic of a timer. The pin is first brought into the clock domain by a short synchronizer. It is then sampled into a five-deep history register. The filtered level moves only when the whole history agrees, and it keeps its last value otherwise. A one-cycle strobe reports the chosen transition of the filtered level to the capture logic.

Sampling has two modes. In bypass mode a sample is taken on every clock, so any level that lasts five clocks gets through. In filter mode a free-running prescaler produces a sampling enable once every 2, 8, 32 or 128 clocks, chosen by a 2-bit select. A pulse must then last five sampling periods to be accepted. After reset the filtered level is held low and marked invalid. It becomes valid only once five consecutive low samples have been taken.

Top module: `capture_glitch_filter`

## Requirements
- R1: The pin passes through a two-register synchronizer. In bypass mode a steady level driven on the pin reaches `filt_level` on the eighth rising clock edge after the change.
- R2: With `filt_en` = 0, a sample is taken on every clock. A high pulse that lasts 6 clocks is passed to `filt_level`.
- R3: With `filt_en` = 1, a sample is taken once every 2, 8, 32 or 128 clocks, for `rate_sel` = 0, 1, 2 or 3. The enable comes from a free-running counter that is cleared by reset: a sample is taken when the counter's low 1, 3, 5 or 7 bits are all ones.
- R4: `filt_level` keeps its value unless all five history samples are equal. A pulse that covers only four samples has no effect on `filt_level` and produces no strobe.
- R5: After reset, `filt_level` stays 0 and `level_valid` stays 0 until five consecutive low samples have been taken. After that, `level_valid` stays 1 until the next reset.
- R6: When filtering is enabled, a pulse that covers at least five samples at the selected rate is passed to `filt_level`.
- R7: `cap_strobe` pulses for exactly one cycle, in the same cycle that `filt_level` changes. It pulses on a 0-to-1 change when `edge_sel` = 0, and on a 1-to-0 change when `edge_sel` = 1.
- R8: Changing `filt_en` clears neither the sample history nor `filt_level`. With a steady pin, the level holds and no strobe occurs.
- R9: A synchronous active-high `rst` clears the synchronizer, history, prescaler, `filt_level`, `level_valid` and `cap_strobe` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| filt_en | input | 1 | 1 = prescaled sampling, 0 = sample every clock |
| rate_sel | input | 2 | Sampling divider select: 2, 8, 32, 128 |
| edge_sel | input | 1 | Strobe edge: 0 = rising, 1 = falling |
| pin_in | input | 1 | Asynchronous capture pin |
| filt_level | output | 1 | Filtered, registered pin level |
| level_valid | output | 1 | Filtered level valid since reset |
| cap_strobe | output | 1 | One-cycle capture strobe on the selected edge |

## Verification
A history register that shifts at the wrong time, or a prescaler with the wrong phase, moves the cycle in which `filt_level` and `cap_strobe` change. A cycle-exact reference in the bench catches that on the first affected transition. A match detector that is too lenient lets a four-sample pulse through within a few sampling periods of the pulse. A faulty valid counter shows up within the first ten cycles after reset. A strobe on the wrong edge shows up at the first filtered transition.

// File: rtl/cgf_pkg.sv
package cgf_pkg;
  localparam int CGF_STAGES     = 5;
  localparam int CGF_SYNC_DEPTH = 2;
  localparam int CGF_CNT_W      = 7;
endpackage

// File: rtl/cgf_sync.sv
module cgf_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= {stage_q[DEPTH-2:0], d};
  end

  assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/cgf_tick.sv
module cgf_tick #(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       filt_en,
  input  logic [1:0] rate_sel,
  output logic       samp_en
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  // low 2*sel+1 bits must be ones
  always_comb begin
    for (int b = 0; b < CNT_W; b++) mask[b] = (b <= 2 * int'(rate_sel));
  end

  assign samp_en = !filt_en || ((cnt_q & mask) == mask);

  // prescaled enable never fires on two adjacent clocks
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (filt_en && samp_en) |=> (!filt_en || !samp_en));
endmodule

// File: rtl/cgf_chain.sv
module cgf_chain #(
  parameter int STAGES = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic samp_en,
  input  logic din,
  input  logic edge_sel,
  output logic lvl,
  output logic valid,
  output logic stb
);
  localparam int LCW = $clog2(STAGES + 1);

  logic [STAGES-1:0] hist_q;
  logic [LCW-1:0]    lows_q;
  logic              valid_q, lvl_q, stb_q;
  logic              all_hi, all_lo, lvl_d;

  assign all_hi = &hist_q;
  assign all_lo = ~|hist_q;
  assign lvl_d  = !valid_q ? 1'b0 : all_hi ? 1'b1 : all_lo ? 1'b0 : lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q  <= '0;
      lows_q  <= '0;
      valid_q <= 1'b0;
      lvl_q   <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      if (samp_en) begin
        hist_q <= {hist_q[STAGES-2:0], din};
        if (din) lows_q <= '0;
        else if (lows_q == LCW'(STAGES - 1)) valid_q <= 1'b1;
        else lows_q <= lows_q + 1'b1;
      end
      lvl_q <= lvl_d;
      stb_q <= (lvl_d != lvl_q) && (lvl_d == !edge_sel);
    end
  end

  assign lvl   = lvl_q;
  assign valid = valid_q;
  assign stb   = stb_q;

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !all_hi && !all_lo) |=> $stable(lvl_q));
  assert_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_q && all_hi) |=> lvl_q);
  assert_invalid_low_R5: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> !lvl_q);
  assert_valid_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> valid_q);
  assert_strobe_change_R7: assert property (@(posedge clk) disable iff (rst)
    stb_q |-> (lvl_q != $past(lvl_q)));
  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
    stb_q |=> !stb_q);
endmodule

// File: rtl/capture_glitch_filter.sv
module capture_glitch_filter
  import cgf_pkg::*;
#(
  parameter int STAGES     = CGF_STAGES,
  parameter int SYNC_DEPTH = CGF_SYNC_DEPTH,
  parameter int CNT_W      = CGF_CNT_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       filt_en,
  input  logic [1:0] rate_sel,
  input  logic       edge_sel,
  input  logic       pin_in,
  output logic       filt_level,
  output logic       level_valid,
  output logic       cap_strobe
);
  logic pin_s, samp_en;

  cgf_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  cgf_tick #(.CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst(rst), .filt_en(filt_en), .rate_sel(rate_sel),
    .samp_en(samp_en)
  );

  cgf_chain #(.STAGES(STAGES)) u_chain (
    .clk(clk), .rst(rst), .samp_en(samp_en), .din(pin_s),
    .edge_sel(edge_sel), .lvl(filt_level), .valid(level_valid),
    .stb(cap_strobe)
  );

  // R9: reset leaves all outputs low on the next cycle
  assert_reset_clear_R9: assert property (@(posedge clk)
    $past(rst) |-> (!filt_level && !level_valid && !cap_strobe));
endmodule

// File: tb/capture_glitch_filter_test.sv
module capture_glitch_filter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic filt_en = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic edge_sel = 1'b0;
  logic pin_in = 1'b0;
  logic filt_level, level_valid, cap_strobe;

  int tests = 0, fails = 0, stb_cnt = 0;
  string cur_req = "R9";
  bit started = 1'b0;

  always #5 clk = ~clk;

  capture_glitch_filter uut (
    .clk(clk), .rst(rst), .filt_en(filt_en), .rate_sel(rate_sel),
    .edge_sel(edge_sel), .pin_in(pin_in), .filt_level(filt_level),
    .level_valid(level_valid), .cap_strobe(cap_strobe)
  );

  // behavioural reference
  int m_s1, m_s2, m_cnt, m_lows, m_valid, m_lvl, m_stb;
  int m_hist[5];

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_cnt = 0; m_lows = 0;
      m_valid = 0; m_lvl = 0; m_stb = 0;
      foreach (m_hist[i]) m_hist[i] = 0;
    end else begin
      int div, ones, nlvl, samp;
      div  = 2 << (2 * rate_sel);
      samp = (!filt_en || (m_cnt % div) == div - 1) ? 1 : 0;
      ones = 0;
      foreach (m_hist[i]) ones += m_hist[i];
      if (!m_valid)      nlvl = 0;
      else if (ones == 5) nlvl = 1;
      else if (ones == 0) nlvl = 0;
      else                nlvl = m_lvl;
      m_stb = (nlvl != m_lvl && nlvl == (edge_sel ? 0 : 1)) ? 1 : 0;
      if (samp) begin
        for (int i = 4; i > 0; i--) m_hist[i] = m_hist[i-1];
        m_hist[0] = m_s2;
        if (m_s2) m_lows = 0;
        else begin
          m_lows++;
          if (m_lows >= 5) m_valid = 1;
        end
      end
      m_lvl = nlvl;
      m_cnt = (m_cnt + 1) % 128;
      m_s2 = m_s1;
      m_s1 = pin_in;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      check(filt_level == m_lvl[0], {cur_req, " level"}, filt_level, m_lvl);
      check(level_valid == m_valid[0], {cur_req, " valid"}, level_valid, m_valid);
      check(cap_strobe == m_stb[0], {cur_req, " strobe"}, cap_strobe, m_stb);
      if (cap_strobe) stb_cnt++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    cyc(3);
    started = 1'b1;
    // R9 reset state
    check(!filt_level && !level_valid && !cap_strobe, "R9",
          {filt_level, level_valid, cap_strobe}, 0);
    rst = 1'b0;
    cur_req = "R5";
    cyc(3);
    check(level_valid == 1'b0, "R5 early", level_valid, 0);
    cyc(10);
    check(level_valid == 1'b1, "R5 late", level_valid, 1);

    // R4: short bypass pulse rejected
    cur_req = "R4";
    base = stb_cnt;
    pin_in = 1'b1; cyc(4); pin_in = 1'b0; cyc(20);
    check(filt_level == 1'b0 && stb_cnt == base, "R4 bypass", stb_cnt - base, 0);

    // R1/R2: six-clock pulse passes, latency 8 edges
    cur_req = "R1";
    base = stb_cnt;
    pin_in = 1'b1; cyc(7);
    check(filt_level == 1'b0, "R1 before", filt_level, 0);
    cyc(1);
    check(filt_level == 1'b1, "R1 at 8", filt_level, 1);
    cur_req = "R2";
    cyc(10);
    check(filt_level == 1'b1 && stb_cnt == base + 1, "R2/R7 rise", stb_cnt - base, 1);

    // R7: edge select
    cur_req = "R7";
    base = stb_cnt;
    pin_in = 1'b0; cyc(15);
    check(stb_cnt == base, "R7 fall ignored", stb_cnt - base, 0);
    edge_sel = 1'b1;
    pin_in = 1'b1; cyc(15);
    check(stb_cnt == base, "R7 rise ignored", stb_cnt - base, 0);
    pin_in = 1'b0; cyc(15);
    check(stb_cnt == base + 1, "R7 fall strobe", stb_cnt - base, 1);
    edge_sel = 1'b0;

    // R3/R4/R6: prescaled sampling at every rate
    filt_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      int div;
      rate_sel = 2'(s);
      div = 2 << (2 * s);
      cur_req = "R3";
      cyc(2 * div);
      base = stb_cnt;
      pin_in = 1'b1; cyc(4 * div); pin_in = 1'b0; cyc(8 * div);
      check(filt_level == 1'b0 && stb_cnt == base, "R3 short pulse at rate",
            stb_cnt - base, 0);
      cur_req = "R6";
      pin_in = 1'b1; cyc(7 * div);
      check(filt_level == 1'b1, "R6 long pulse", filt_level, 1);
      pin_in = 1'b0; cyc(8 * div);
      check(filt_level == 1'b0 && stb_cnt == base + 1, "R6 strobes",
            stb_cnt - base, 1);
    end

    // R8: mode change keeps state
    cur_req = "R8";
    rate_sel = 2'd0;
    pin_in = 1'b1; cyc(20);
    base = stb_cnt;
    filt_en = 1'b0; cyc(6);
    check(filt_level == 1'b1 && stb_cnt == base, "R8 switch off", stb_cnt - base, 0);
    filt_en = 1'b1; cyc(6);
    check(filt_level == 1'b1 && stb_cnt == base, "R8 switch on", stb_cnt - base, 0);
    pin_in = 1'b0; cyc(20);

    // R9: reset mid-run
    cur_req = "R9";
    pin_in = 1'b1; cyc(20);
    rst = 1'b1; cyc(2);
    check(!filt_level && !level_valid && !cap_strobe, "R9 rerun",
          {filt_level, level_valid, cap_strobe}, 0);
    rst = 1'b0; cyc(10);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule